// File: doc/BRIEF.md
# Environment-Configuration CSR Access Guard

This block stores the environment-configuration registers of a hart with hypervisor support, together with the three state-enable words that control access to them. It decides, in the same cycle as the request, whether a CSR read or write to one of those registers may proceed. The CSR pipeline presents an address, read and write strobes, write data, the current privilege level and the virtualization flag. The block answers with read data, a grant flag and an exception code.

The check runs in layers. First the machine-level state-enable word is consulted. Next comes the hypervisor-level word, but only while virtualized. Last comes the supervisor-level word, but only for user-mode accesses on a hart that implements supervisor mode. Which layer refuses the access decides between an illegal-instruction fault and a virtual-instruction fault. Machine-mode accesses skip the check entirely, and so does every access while the state-enable strap is off.

Writes to the state-enable words and to the envcfg registers are field-masked. Only architecturally defined fields change. Instruction decode, trap entry and CSR privilege legality live elsewhere.

Top module: `csr_envcfg_guard`

## Requirements
- R1: With `cfg_stateen_en` low, every envcfg access (senvcfg 0x10A, henvcfg 0x60A, henvcfgh 0x61A on RV32) is granted with `exc_code` 2'b00 (none).
- R2: An access with `priv_mode` 2'b11 (machine) is always granted with `exc_code` 2'b00, whatever the state-enable bits hold.
- R3: From S (2'b01) or U (2'b00) mode with the strap on, a clear gate bit (bit 62) in machine stateen0 (0x30C) gives `exc_code` 2'b01 (illegal instruction). This takes priority over every other layer.
- R4: While `virt_on` is high and the machine gate bit is set, a clear gate bit 62 in hypervisor stateen0 (0x60C) gives `exc_code` 2'b10 (virtual instruction).
- R5: From U mode with `cfg_has_smode` high, a clear gate bit 62 in supervisor stateen0 (0x10C) makes the access fault. The code is 2'b01 when not virtualized and 2'b10 in VU mode.
- R6: With `cfg_has_smode` low, the supervisor stateen0 gate bit has no effect on U-mode accesses.
- R7: A faulting access returns zero read data, deasserts `grant` and updates no register.
- R8: In machine and hypervisor stateen0 only bits 63 and 62 are writable. In supervisor stateen0 only bit 62 is writable. All other bits read as zero.
- R9: A senvcfg write changes only bits 0, 5:4, 6 and 7 and leaves the rest unchanged.
- R10: A henvcfg write changes bits 0, 5:4, 6 and 7, and on RV64 (`cfg_rv32` low) also bits 62 and 63. On RV32 it reads back only the low 32 bits, zero-extended.
- R11: On RV32, henvcfgh reads return henvcfg bits 63:32, and a henvcfgh write changes only henvcfg bits 63:62 (taken from write-data bits 31:30). On RV64, henvcfgh is not recognised.
- R12: The state-enable words reset to zero. An idle cycle or an unrecognised address gives `grant` low, `exc_code` 2'b00 and zero read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_stateen_en | input | 1 | Strap: state-enable gating implemented |
| cfg_has_smode | input | 1 | Strap: supervisor mode implemented |
| cfg_rv32 | input | 1 | Strap: XLEN is 32 |
| priv_mode | input | 2 | Current privilege: 00 U, 01 S, 11 M |
| virt_on | input | 1 | Hart is virtualized (VS/VU) |
| csr_addr | input | 12 | CSR address |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 64 | Write data |
| rd_data | output | 64 | Read data, zero unless granted |
| grant | output | 1 | Access is served and allowed |
| exc_code | output | 2 | 00 none, 01 illegal instruction, 10 virtual instruction |

## Verification
The hardest case to reach is a VU-mode access that passes both the machine and the hypervisor layers but is refused by the supervisor layer. Here the code must turn into a virtual-instruction fault instead of an illegal one. The stimulus reaches it from machine mode: it sets both upper gate bits, clears only the supervisor gate, and then issues the same read from U and from VU. The bench then drops the S-mode strap and repeats the read to show that the supervisor word stops mattering.

// File: rtl/csr_envcfg_pkg.sv
// Package: shared constants, field positions, masks and types for the
// envcfg access guard. Assumes a 64-bit storage width for all registers.
package csr_envcfg_pkg;

    localparam int DW         = 64;
    localparam int HALF_W     = DW / 2;

    // state-enable word field positions
    localparam int STATEN_BIT = 63;
    localparam int GATE_BIT   = 62;

    // envcfg field positions
    localparam int FIOM_BIT   = 0;
    localparam int CBIE_LO    = 4;
    localparam int CBCFE_BIT  = 6;
    localparam int CBZE_BIT   = 7;
    localparam int PBMTE_BIT  = 62;
    localparam int STCE_BIT   = 63;

    localparam logic [DW-1:0] ENV_LO_MASK = (DW'(1) << FIOM_BIT) | (DW'(3) << CBIE_LO)
                                          | (DW'(1) << CBCFE_BIT) | (DW'(1) << CBZE_BIT);
    localparam logic [DW-1:0] ENV_HI_MASK = (DW'(1) << PBMTE_BIT) | (DW'(1) << STCE_BIT);
    localparam logic [DW-1:0] UPPER_STE_MASK = (DW'(1) << STATEN_BIT) | (DW'(1) << GATE_BIT);
    localparam logic [DW-1:0] SUP_STE_MASK   = DW'(1) << GATE_BIT;

    // privilege encodings
    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_S = 2'b01;
    localparam logic [1:0] PRIV_M = 2'b11;

    // exception encodings
    localparam logic [1:0] EXC_NONE    = 2'b00;
    localparam logic [1:0] EXC_ILLEGAL = 2'b01;
    localparam logic [1:0] EXC_VIRTUAL = 2'b10;

    // CSR addresses served here
    localparam logic [11:0] A_SENVCFG   = 12'h10A;
    localparam logic [11:0] A_SSTATEEN0 = 12'h10C;
    localparam logic [11:0] A_MSTATEEN0 = 12'h30C;
    localparam logic [11:0] A_HENVCFG   = 12'h60A;
    localparam logic [11:0] A_HSTATEEN0 = 12'h60C;
    localparam logic [11:0] A_HENVCFGH  = 12'h61A;

    typedef struct packed {
        logic senv;
        logic henv;
        logic henvh;
        logic mste;
        logic hste;
        logic sste;
    } csr_sel_t;

    function automatic logic [DW-1:0] masked_merge(input logic [DW-1:0] old_v,
                                                   input logic [DW-1:0] new_v,
                                                   input logic [DW-1:0] mask);
        return (old_v & ~mask) | (new_v & mask);
    endfunction

endpackage

// File: rtl/envcfg_csr_decode.sv
// Module: address decode. Produces one-hot select of the register addressed
// and whether it lies in the gated envcfg group. Assumes 12-bit addresses;
// the upper-half alias exists only when XLEN is 32.
module envcfg_csr_decode
    import csr_envcfg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_rv32,
    output csr_sel_t          sel,
    output logic              env_hit,
    output logic              any_hit
);

    // compare the address against every served register
    always_comb begin
        sel.senv  = (addr == ADDR_W'(A_SENVCFG));
        sel.henv  = (addr == ADDR_W'(A_HENVCFG));
        sel.henvh = (addr == ADDR_W'(A_HENVCFGH)) && is_rv32;
        sel.mste  = (addr == ADDR_W'(A_MSTATEEN0));
        sel.hste  = (addr == ADDR_W'(A_HSTATEEN0));
        sel.sste  = (addr == ADDR_W'(A_SSTATEEN0));
        env_hit   = sel.senv | sel.henv | sel.henvh;
        any_hit   = |sel;
    end

endmodule

// File: rtl/envcfg_gate_check.sv
// Module: layered permission check for envcfg accesses. Machine layer first,
// then the hypervisor layer when virtualized, then the supervisor layer for
// user mode when supervisor mode exists. Purely combinational.
module envcfg_gate_check
    import csr_envcfg_pkg::*;
(
    input  logic       check,
    input  logic       gate_en,
    input  logic       has_smode,
    input  logic [1:0] priv,
    input  logic       virt,
    input  logic       m_gate,
    input  logic       h_gate,
    input  logic       s_gate,
    output logic [1:0] exc
);

    // walk the layers in priority order
    always_comb begin
        exc = EXC_NONE;
        if (check && gate_en && priv != PRIV_M) begin
            if (!m_gate) begin
                exc = EXC_ILLEGAL;
            end else if (virt && !h_gate) begin
                exc = EXC_VIRTUAL;
            end else if (priv == PRIV_U && has_smode && !s_gate) begin
                exc = virt ? EXC_VIRTUAL : EXC_ILLEGAL;
            end
        end
    end

endmodule

// File: rtl/envcfg_regs.sv
// Module: storage for the three state-enable words and the two envcfg
// registers, with field-masked writes. Assumes wr_en is already qualified
// by the permission check and that sel is one-hot or zero.
module envcfg_regs
    import csr_envcfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  csr_sel_t      sel,
    input  logic          wr_en,
    input  logic          is_rv32,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] mste_q,
    output logic [DW-1:0] hste_q,
    output logic [DW-1:0] sste_q,
    output logic [DW-1:0] senv_q,
    output logic [DW-1:0] henv_q
);

    localparam int N_UPPER = 2;

    logic [N_UPPER-1:0]         upper_sel;
    logic [N_UPPER-1:0][DW-1:0] upper_q;
    logic [DW-1:0]              henv_mask;

    assign upper_sel = {sel.hste, sel.mste};
    assign henv_mask = is_rv32 ? ENV_LO_MASK : (ENV_LO_MASK | ENV_HI_MASK);

    // machine and hypervisor state-enable words share one write rule
    for (genvar g = 0; g < N_UPPER; g++) begin : g_upper
        // masked update of one upper-level state-enable word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                upper_q[g] <= '0;
            end else if (wr_en && upper_sel[g]) begin
                upper_q[g] <= wdata & UPPER_STE_MASK;
            end
        end
    end

    assign mste_q = upper_q[0];
    assign hste_q = upper_q[1];

    // supervisor state-enable word: gate bit only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sste_q <= '0;
        end else if (wr_en && sel.sste) begin
            sste_q <= wdata & SUP_STE_MASK;
        end
    end

    // supervisor envcfg: low fields only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            senv_q <= '0;
        end else if (wr_en && sel.senv) begin
            senv_q <= masked_merge(senv_q, wdata, ENV_LO_MASK);
        end
    end

    // hypervisor envcfg: full-word or upper-half alias write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            henv_q <= '0;
        end else if (wr_en && sel.henv) begin
            henv_q <= masked_merge(henv_q, wdata, henv_mask);
        end else if (wr_en && sel.henvh) begin
            henv_q <= masked_merge(henv_q, {wdata[HALF_W-1:0], {HALF_W{1'b0}}}, ENV_HI_MASK);
        end
    end

endmodule

// File: rtl/csr_envcfg_guard.sv
// Module: top of the envcfg access guard. Decodes the address, runs the
// layered check, gates the register write and muxes read data. Outputs
// are combinational on the request; writes land on the next clock edge.
module csr_envcfg_guard
    import csr_envcfg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_stateen_en,
    input  logic              cfg_has_smode,
    input  logic              cfg_rv32,
    input  logic [1:0]        priv_mode,
    input  logic              virt_on,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              csr_rd,
    input  logic              csr_wr,
    input  logic [63:0]       csr_wdata,
    output logic [63:0]       rd_data,
    output logic              grant,
    output logic [1:0]        exc_code
);

    csr_sel_t      sel;
    logic          env_hit;
    logic          any_hit;
    logic          access;
    logic [1:0]    exc;
    logic [DW-1:0] mste_q, hste_q, sste_q, senv_q, henv_q;
    logic [DW-1:0] rd_mux;

    assign access = csr_rd | csr_wr;

    envcfg_csr_decode #(.ADDR_W(ADDR_W)) i_dec (
        .addr    (csr_addr),
        .is_rv32 (cfg_rv32),
        .sel     (sel),
        .env_hit (env_hit),
        .any_hit (any_hit)
    );

    envcfg_gate_check i_chk_gate (
        .check     (access & env_hit),
        .gate_en   (cfg_stateen_en),
        .has_smode (cfg_has_smode),
        .priv      (priv_mode),
        .virt      (virt_on),
        .m_gate    (mste_q[GATE_BIT]),
        .h_gate    (hste_q[GATE_BIT]),
        .s_gate    (sste_q[GATE_BIT]),
        .exc       (exc)
    );

    assign grant    = access & any_hit & (exc == EXC_NONE);
    assign exc_code = exc;

    envcfg_regs i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .wr_en   (grant & csr_wr),
        .is_rv32 (cfg_rv32),
        .wdata   (csr_wdata),
        .mste_q  (mste_q),
        .hste_q  (hste_q),
        .sste_q  (sste_q),
        .senv_q  (senv_q),
        .henv_q  (henv_q)
    );

    // select the addressed register, narrowing henvcfg on RV32
    always_comb begin
        rd_mux = '0;
        if (sel.senv)  rd_mux = senv_q;
        if (sel.henv)  rd_mux = cfg_rv32 ? {{HALF_W{1'b0}}, henv_q[HALF_W-1:0]} : henv_q;
        if (sel.henvh) rd_mux = {{HALF_W{1'b0}}, henv_q[DW-1:HALF_W]};
        if (sel.mste)  rd_mux = mste_q;
        if (sel.hste)  rd_mux = hste_q;
        if (sel.sste)  rd_mux = sste_q;
    end

    assign rd_data = grant ? rd_mux : '0;

endmodule

// File: rtl/csr_envcfg_guard_chk.sv
// Module: assertion checker for csr_envcfg_guard, attached by bind below.
module csr_envcfg_guard_chk
    import csr_envcfg_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_stateen_en,
    input logic [1:0]    priv_mode,
    input logic          virt_on,
    input logic          csr_rd,
    input logic          csr_wr,
    input logic [63:0]   rd_data,
    input logic          grant,
    input logic [1:0]    exc_code,
    input logic [DW-1:0] mste_q,
    input logic [DW-1:0] hste_q,
    input logic [DW-1:0] sste_q,
    input logic [DW-1:0] senv_q,
    input logic [DW-1:0] henv_q
);

    a_r1_strap_off_clean: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_stateen_en |-> exc_code == EXC_NONE);

    a_r2_machine_clean: assert property (@(posedge clk) disable iff (!rst_n)
        priv_mode == PRIV_M |-> exc_code == EXC_NONE);

    a_r4_virtual_needs_virt: assert property (@(posedge clk) disable iff (!rst_n)
        exc_code == EXC_VIRTUAL |-> virt_on);

    a_r7_fault_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        exc_code != EXC_NONE |-> (rd_data == '0 && !grant));

    a_r7_fault_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_code != EXC_NONE && csr_wr) |=> ($stable(senv_q) && $stable(henv_q)
            && $stable(mste_q) && $stable(hste_q) && $stable(sste_q)));

    a_r8_stateen_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((mste_q & ~UPPER_STE_MASK) == '0) && ((hste_q & ~UPPER_STE_MASK) == '0)
            && ((sste_q & ~SUP_STE_MASK) == '0));

    a_r9_senv_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (senv_q & ~ENV_LO_MASK) == '0);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_rd || csr_wr) |-> (!grant && exc_code == EXC_NONE && rd_data == '0));

endmodule

bind csr_envcfg_guard csr_envcfg_guard_chk i_guard_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_stateen_en (cfg_stateen_en),
    .priv_mode      (priv_mode),
    .virt_on        (virt_on),
    .csr_rd         (csr_rd),
    .csr_wr         (csr_wr),
    .rd_data        (rd_data),
    .grant          (grant),
    .exc_code       (exc_code),
    .mste_q         (mste_q),
    .hste_q         (hste_q),
    .sste_q         (sste_q),
    .senv_q         (senv_q),
    .henv_q         (henv_q)
);

// File: tb/test_csr_envcfg_guard.sv
// Bench: behavioural reference model of the register state and permission
// rules, compared against the design on every request cycle.
module test_csr_envcfg_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_stateen_en = 1'b1;
    logic        cfg_has_smode = 1'b1;
    logic        cfg_rv32 = 1'b0;
    logic [1:0]  priv_mode = 2'b11;
    logic        virt_on = 1'b0;
    logic [11:0] csr_addr = '0;
    logic        csr_rd = 1'b0;
    logic        csr_wr = 1'b0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] rd_data;
    logic        grant;
    logic [1:0]  exc_code;

    int checks = 0;
    int errors = 0;

    // model state
    logic [63:0] md_m = '0, md_h = '0, md_s = '0, md_senv = '0, md_henv = '0;

    localparam logic [63:0] LO  = 64'h0000_0000_0000_00F1;
    localparam logic [63:0] HI  = 64'hC000_0000_0000_0000;
    localparam logic [63:0] ONES = '1;

    always #5 clk = ~clk;

    csr_envcfg_guard i_csr_envcfg_guard (
        .clk(clk), .rst_n(rst_n), .cfg_stateen_en(cfg_stateen_en),
        .cfg_has_smode(cfg_has_smode), .cfg_rv32(cfg_rv32), .priv_mode(priv_mode),
        .virt_on(virt_on), .csr_addr(csr_addr), .csr_rd(csr_rd), .csr_wr(csr_wr),
        .csr_wdata(csr_wdata), .rd_data(rd_data), .grant(grant), .exc_code(exc_code)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one request cycle: drive, compare, let the edge pass, update model
    task automatic step(input string req, input logic [1:0] p, input logic v,
                        input logic [11:0] a, input logic r, input logic w,
                        input logic [63:0] d);
        logic        env, known, ok;
        logic [1:0]  e;
        logic [63:0] val;
        @(negedge clk);
        priv_mode = p; virt_on = v; csr_addr = a; csr_rd = r; csr_wr = w; csr_wdata = d;
        env = (a == 12'h10A) || (a == 12'h60A) || (a == 12'h61A && cfg_rv32);
        known = env || a == 12'h30C || a == 12'h60C || a == 12'h10C;
        e = 2'b00;
        if ((r || w) && env && cfg_stateen_en && p != 2'b11) begin
            if (!md_m[62]) e = 2'b01;
            else if (v && !md_h[62]) e = 2'b10;
            else if (p == 2'b00 && cfg_has_smode && !md_s[62]) e = v ? 2'b10 : 2'b01;
        end
        ok = (r || w) && known && e == 2'b00;
        case (a)
            12'h10A: val = md_senv;
            12'h60A: val = cfg_rv32 ? {32'b0, md_henv[31:0]} : md_henv;
            12'h61A: val = {32'b0, md_henv[63:32]};
            12'h30C: val = md_m;
            12'h60C: val = md_h;
            12'h10C: val = md_s;
            default: val = '0;
        endcase
        if (!ok) val = '0;
        #2;
        chk(req, "exc_code", 64'(exc_code), 64'(e));
        chk(req, "grant", 64'(grant), 64'(ok));
        chk(req, "rd_data", rd_data, val);
        @(posedge clk);
        #1;
        csr_rd = 1'b0; csr_wr = 1'b0;
        if (ok && w) begin
            case (a)
                12'h10A: md_senv = (md_senv & ~LO) | (d & LO);
                12'h60A: md_henv = cfg_rv32 ? ((md_henv & ~LO) | (d & LO))
                                            : ((md_henv & ~(LO | HI)) | (d & (LO | HI)));
                12'h61A: md_henv = (md_henv & ~HI) | ({d[31:0], 32'b0} & HI);
                12'h30C: md_m = d & HI;
                12'h60C: md_h = d & HI;
                12'h10C: md_s = d & 64'h4000_0000_0000_0000;
                default: ;
            endcase
        end
    endtask

    initial begin : watchdog
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R12: reset values and idle / unknown address
        step("R12", 2'b11, 0, 12'h30C, 1, 0, 0);
        step("R12", 2'b11, 0, 12'h60C, 1, 0, 0);
        step("R12", 2'b11, 0, 12'h123, 1, 0, 0);
        step("R12", 2'b11, 0, 12'h10A, 0, 0, 0);
        // R3: machine gate clear blocks S and U; R7: faulting write has no effect
        step("R3", 2'b01, 0, 12'h10A, 1, 0, 0);
        step("R7", 2'b01, 0, 12'h10A, 0, 1, ONES);
        step("R7", 2'b11, 0, 12'h10A, 1, 0, 0);
        // R8: masked state-enable writes
        step("R8", 2'b11, 0, 12'h30C, 0, 1, ONES);
        step("R8", 2'b11, 0, 12'h30C, 1, 0, 0);
        step("R8", 2'b11, 0, 12'h60C, 0, 1, ONES);
        step("R8", 2'b11, 0, 12'h60C, 1, 0, 0);
        step("R8", 2'b11, 0, 12'h10C, 0, 1, ONES);
        step("R8", 2'b11, 0, 12'h10C, 1, 0, 0);
        // R9 / R10: envcfg field masks
        step("R9", 2'b01, 0, 12'h10A, 0, 1, ONES);
        step("R9", 2'b01, 0, 12'h10A, 1, 0, 0);
        step("R9", 2'b01, 0, 12'h10A, 0, 1, 64'h0000_0000_0000_0020);
        step("R9", 2'b01, 0, 12'h10A, 1, 0, 0);
        step("R10", 2'b01, 0, 12'h60A, 0, 1, ONES);
        step("R10", 2'b01, 0, 12'h60A, 1, 0, 0);
        step("R4", 2'b01, 1, 12'h10A, 1, 0, 0);
        // R4: hypervisor gate clear while virtualized
        step("R4", 2'b11, 0, 12'h60C, 0, 1, 64'h8000_0000_0000_0000);
        step("R4", 2'b01, 1, 12'h10A, 1, 0, 0);
        step("R4", 2'b00, 1, 12'h60A, 1, 0, 0);
        step("R4", 2'b01, 0, 12'h10A, 1, 0, 0);
        // R3 priority over the hypervisor layer
        step("R3", 2'b11, 0, 12'h30C, 0, 1, 0);
        step("R3", 2'b01, 1, 12'h10A, 1, 0, 0);
        step("R3", 2'b00, 0, 12'h10A, 0, 1, ONES);
        step("R3", 2'b11, 0, 12'h30C, 0, 1, ONES);
        step("R3", 2'b11, 0, 12'h60C, 0, 1, ONES);
        // R5: supervisor gate clear for U and VU
        step("R5", 2'b11, 0, 12'h10C, 0, 1, 0);
        step("R5", 2'b00, 0, 12'h10A, 1, 0, 0);
        step("R5", 2'b00, 1, 12'h10A, 1, 0, 0);
        step("R5", 2'b01, 0, 12'h10A, 1, 0, 0);
        step("R5", 2'b00, 1, 12'h10A, 0, 1, 0);
        step("R5", 2'b11, 0, 12'h10A, 1, 0, 0);
        // R6: no supervisor mode, supervisor word ignored
        cfg_has_smode = 1'b0;
        step("R6", 2'b00, 0, 12'h10A, 1, 0, 0);
        step("R6", 2'b00, 1, 12'h60A, 1, 0, 0);
        cfg_has_smode = 1'b1;
        // R1: strap off with every gate clear
        step("R1", 2'b11, 0, 12'h30C, 0, 1, 0);
        cfg_stateen_en = 1'b0;
        step("R1", 2'b01, 1, 12'h10A, 1, 0, 0);
        step("R1", 2'b00, 0, 12'h60A, 0, 1, 64'h0000_0000_0000_0001);
        step("R1", 2'b00, 0, 12'h60A, 1, 0, 0);
        cfg_stateen_en = 1'b1;
        // R2: machine mode ignores gates
        step("R2", 2'b11, 1, 12'h10A, 1, 0, 0);
        step("R2", 2'b11, 0, 12'h60A, 0, 1, ONES);
        // R10 / R11: RV32 views of henvcfg
        cfg_rv32 = 1'b1;
        step("R10", 2'b11, 0, 12'h60A, 0, 1, 0);
        step("R10", 2'b11, 0, 12'h60A, 1, 0, 0);
        step("R11", 2'b11, 0, 12'h61A, 1, 0, 0);
        step("R11", 2'b11, 0, 12'h61A, 0, 1, 0);
        step("R11", 2'b11, 0, 12'h61A, 1, 0, 0);
        step("R11", 2'b11, 0, 12'h61A, 0, 1, 64'h0000_0000_FFFF_FFFF);
        step("R11", 2'b11, 0, 12'h61A, 1, 0, 0);
        step("R11", 2'b01, 0, 12'h61A, 1, 0, 0);
        step("R10", 2'b11, 0, 12'h60A, 0, 1, ONES);
        step("R10", 2'b11, 0, 12'h61A, 1, 0, 0);
        cfg_rv32 = 1'b0;
        step("R11", 2'b11, 0, 12'h61A, 1, 0, 0);
        step("R10", 2'b11, 0, 12'h60A, 1, 0, 0);
        step("R12", 2'b01, 0, 12'h7FF, 0, 1, ONES);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule